// File: doc/BRIEF.md
# Single-Wire Monitor Serial Port

This block is a half-duplex serial port for a debug monitor that shares one bidirectional line with a host. It receives and sends bytes as NRZ frames. Each frame has a low start bit, eight data bits with the least significant bit first, and a high stop bit. Receive and send use the same bit period.

The port also watches for a break. A break is a start bit followed by nine more low bits, so the stop bit is missing. When the port sees a break, it drives the line high for two bit periods and then sends a break back. The port drives the line only while it is sending a frame or answering a break. At all other times the line is released and reads idle high through the external pull-up.

The bit period is a fixed number of input clocks. There are two possible values. A strap pin and a force pin are sampled once, on the `mode_enter` pulse. Strap high, or force high, selects the long period. Otherwise the short period is used.

Received bytes leave the port on a valid/ready stream. `rx_valid` stays high and `rx_data` stays unchanged until the consumer takes the byte with `rx_ready`. A byte that completes while an earlier byte is still waiting is discarded. The earlier byte is kept.

Bytes to send enter on a valid/ready stream. `tx_ready` is high only when the port is fully idle: no reception under way, no break answer under way and no frame being sent. A request that arrives while the port is busy therefore waits, and the whole frame is sent once the port is idle.

Top module: `mon_serial_port`

## Requirements
- R1: After reset, `line_oe` is 0, `rx_valid` is 0 and `tx_ready` is 1. The long period `DIV_HI` is selected until the first `mode_enter`.
- R2: A received frame (low start bit, eight data bits least significant first, high stop bit) presents its data byte on `rx_data` with `rx_valid` high.
- R3: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` does not change. A byte that completes during this time is dropped.
- R4: After a `tx_valid`/`tx_ready` handshake, the next cycle drives `line_oe` high with the start bit (0). Then the eight data bits follow, least significant first, then a stop bit (1). Each bit lasts exactly one bit period, and then the line is released.
- R5: A start bit followed by nine low bits pulses `brk_seen` for one cycle. It produces neither a data byte nor `frame_err`.
- R6: In the cycle after `brk_seen`, the port drives the line high. It holds it high for exactly 2 bit periods, then drives it low for exactly 10 bit periods, then releases it.
- R7: A frame whose stop bit reads 0 and whose data bits are not all 0 pulses `frame_err` and produces no data byte.
- R8: On `mode_enter`, the port selects `DIV_HI` when `strap_hi` is 1 and `DIV_LO` when `strap_hi` is 0. Changes on `strap_hi` between `mode_enter` pulses have no effect.
- R9: When `force_hi` is 1 at `mode_enter`, the period is `DIV_HI` whatever the level of `strap_hi`.
- R10: `tx_ready` is 0 while a reception or a break answer is in progress. A waiting request is sent in full afterwards.
- R11: A low pulse on the line that has ended by half a bit period after its falling edge is not taken as a start bit. It produces no byte and no error.
- R12: `line_oe` rises only in the cycle after a transmit handshake or a `brk_seen` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bit-rate reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_enter | input | 1 | One-cycle pulse that samples the strap and force inputs |
| strap_hi | input | 1 | Strap: 1 selects the long period at mode entry |
| force_hi | input | 1 | Override: 1 forces the long period at mode entry |
| line_in | input | 1 | Level on the shared line |
| line_oe | output | 1 | Drive enable for the shared line |
| line_out | output | 1 | Level driven when `line_oe` is 1 |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Byte to send is presented |
| tx_ready | output | 1 | Port accepts a byte this cycle |
| tx_data | input | 8 | Byte to send |
| brk_seen | output | 1 | One-cycle pulse on break detection |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
The assertions check the following on every cycle:
- the receive output holds while it is stalled;
- the start bit appears right after a transmit handshake;
- the line is driven high in the cycle after a break;
- a break never raises a framing error;
- `line_oe` only turns on after a handshake or a break.

The bench scenarios are needed for everything that depends on time spent on the line:
- the exact 2-period high phase and 10-period low phase of the break answer;
- the bit order of received and sent frames;
- which period gets latched from the strap and force inputs;
- glitch rejection;
- a send request that is held back until a reception ends.

// File: rtl/mon_pkg.sv
package mon_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int BRK_HIGH   = 2;
  localparam int BRK_LOW    = DATA_BITS + 2;
  localparam int TX_SLOTS   = BRK_HIGH + BRK_LOW;
  localparam int SLOT_W     = $clog2(TX_SLOTS + 1);
  localparam int IDX_W      = $clog2(DATA_BITS);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/mon_baud.sv
module mon_baud #(
  parameter int DIV_HI = 1024,
  parameter int DIV_LO = 512,
  parameter int CW     = $clog2(DIV_HI + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_enter,
  input  logic          strap_hi,
  input  logic          force_hi,
  output logic [CW-1:0] period
);
  logic sel_hi;

  // Strap and override are captured only on mode entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_hi <= 1'b1;
    else if (mode_enter) sel_hi <= strap_hi | force_hi;
  end

  assign period = sel_hi ? CW'(DIV_HI) : CW'(DIV_LO);
endmodule

// File: rtl/mon_rx.sv
module mon_rx
  import mon_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 line,
  input  logic [CW-1:0]        period,
  output logic                 byte_done,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 brk,
  output logic                 ferr,
  output logic                 idle
);
  rx_state_t            state;
  logic [CW-1:0]        cnt;
  logic [IDX_W-1:0]     bit_i;
  logic [DATA_BITS-1:0] shreg;
  logic                 line_q;
  logic [CW-1:0]        half;
  logic                 bit_end;

  assign half      = period >> 1;
  assign bit_end   = (cnt == period - CW'(1));
  assign idle      = (state == RX_IDLE);
  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bit_i     <= '0;
      shreg     <= '0;
      line_q    <= 1'b1;
      byte_done <= 1'b0;
      brk       <= 1'b0;
      ferr      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      brk       <= 1'b0;
      ferr      <= 1'b0;
      line_q    <= line;
      if (!en) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          RX_IDLE: begin
            if (line_q && !line) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == half - CW'(1)) begin
              cnt <= '0;
              if (!line) begin
                state <= RX_DATA;
                bit_i <= '0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          RX_DATA: begin
            if (bit_end) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_BITS-1:1]};
              if (bit_i == IDX_W'(DATA_BITS - 1)) state <= RX_STOP;
              else bit_i <= bit_i + IDX_W'(1);
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          RX_STOP: begin
            if (bit_end) begin
              cnt   <= '0;
              state <= RX_IDLE;
              if (line)            byte_done <= 1'b1;
              else if (shreg == 0) brk       <= 1'b1;
              else                 ferr      <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        period,
  input  logic                 start_byte,
  input  logic [DATA_BITS-1:0] byte_in,
  input  logic                 start_brk,
  output logic                 busy,
  output logic                 line_out
);
  logic [TX_SLOTS-1:0] shreg;
  logic [SLOT_W-1:0]   left;
  logic [CW-1:0]       cnt;

  // Frame: start 0, data LSB first, stop 1; padded high to the slot width.
  localparam int PAD = TX_SLOTS - FRAME_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (start_brk) begin
      shreg <= {{BRK_LOW{1'b0}}, {BRK_HIGH{1'b1}}};
      left  <= SLOT_W'(TX_SLOTS);
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (start_byte) begin
      shreg <= {{PAD{1'b1}}, 1'b1, byte_in, 1'b0};
      left  <= SLOT_W'(FRAME_BITS);
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt == period - CW'(1)) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[TX_SLOTS-1:1]};
        left  <= left - SLOT_W'(1);
        if (left == SLOT_W'(1)) busy <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign line_out = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/mon_serial_port.sv
module mon_serial_port
  import mon_pkg::*;
#(
  parameter int DIV_HI = 1024,
  parameter int DIV_LO = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_enter,
  input  logic       strap_hi,
  input  logic       force_hi,
  input  logic       line_in,
  output logic       line_oe,
  output logic       line_out,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       brk_seen,
  output logic       frame_err
);
  localparam int CW   = $clog2(DIV_HI + 1);
  localparam int SYNC = 2;

  logic [CW-1:0]        period;
  logic [SYNC-1:0]      sync_q;
  logic                 line_s;
  logic                 rx_done, rx_brk, rx_ferr, rx_idle;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 tx_busy, tx_go;

  mon_baud #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .CW(CW)) baud_i (
    .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter),
    .strap_hi(strap_hi), .force_hi(force_hi), .period(period)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], line_in};
  end
  assign line_s = sync_q[SYNC-1];

  mon_rx #(.CW(CW)) rx_i (
    .clk(clk), .rst_n(rst_n), .en(!tx_busy), .line(line_s), .period(period),
    .byte_done(rx_done), .byte_data(rx_byte), .brk(rx_brk), .ferr(rx_ferr),
    .idle(rx_idle)
  );

  assign tx_ready = !tx_busy && rx_idle && !rx_brk;
  assign tx_go    = tx_valid && tx_ready;

  mon_tx #(.CW(CW)) tx_i (
    .clk(clk), .rst_n(rst_n), .period(period), .start_byte(tx_go),
    .byte_in(tx_data), .start_brk(rx_brk), .busy(tx_busy), .line_out(line_out)
  );

  // Received-byte holding stage: a held byte wins over a newer one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (rx_done && (!rx_valid || rx_ready)) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_byte;
      end
    end
  end

  assign line_oe   = tx_busy;
  assign brk_seen  = rx_brk;
  assign frame_err = rx_ferr;
endmodule

// File: rtl/mon_serial_port_chk.sv
module mon_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_oe,
  input logic       line_out,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       brk_seen,
  input logic       frame_err
);
  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  assert_start_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> line_oe && !line_out);

  assert_brk_no_ferr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_seen |-> !frame_err);

  assert_brk_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_seen |=> line_oe && line_out);

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !tx_ready);

  assert_oe_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(brk_seen) || $past(tx_valid && tx_ready));
endmodule

bind mon_serial_port mon_serial_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .line_oe(line_oe), .line_out(line_out),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .brk_seen(brk_seen),
  .frame_err(frame_err)
);

// File: tb/mon_serial_port_tb.sv
module mon_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 32;
  localparam int PL = 16;

  logic clk = 0, rst_n = 0;
  logic mode_enter = 0, strap_hi = 1, force_hi = 0;
  logic host_drv = 1;
  logic line_oe, line_out, line_bus;
  logic rx_valid, rx_ready = 1, tx_valid = 0, tx_ready, brk_seen, frame_err;
  logic [7:0] rx_data, tx_data = 0;

  int vectors = 0, fails = 0, brk_cnt = 0, ferr_cnt = 0, rx_cnt = 0;
  bit done = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line_bus = line_oe ? line_out : host_drv;

  mon_serial_port #(.DIV_HI(PH), .DIV_LO(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .strap_hi(strap_hi),
    .force_hi(force_hi), .line_in(line_bus), .line_oe(line_oe),
    .line_out(line_out), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .brk_seen(brk_seen), .frame_err(frame_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (brk_seen)  brk_cnt++;
    if (frame_err) ferr_cnt++;
  end

  // Monitor: pops expected bytes as the design hands them over.
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      rx_cnt++;
      if (exp_q.size() == 0) chk("R2 unexpected byte", rx_data, -1);
      else chk("R2 rx byte", rx_data, exp_q.pop_front());
    end
  end

  task automatic host_bits(input logic [11:0] bits, input int n, input int p);
    for (int i = 0; i < n; i++) begin
      host_drv = bits[i];
      repeat (p) @(negedge clk);
    end
    host_drv = 1;
  endtask

  // Driver: pushes the expected byte, then plays the frame on the line.
  task automatic host_byte(input logic [7:0] d, input int p, input bit expect_it);
    if (expect_it) exp_q.push_back(d);
    host_bits({3'b001, d, 1'b0}, 10, p);
    repeat (p) @(negedge clk);
  endtask

  task automatic tx_expect(input logic [7:0] d, input int p, input string req);
    logic [9:0] f, got;
    f = {1'b1, d, 1'b0};
    got = '0;
    tx_data  = d;
    tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 0;
    repeat (p/2) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      got[k] = line_oe && (line_out == f[k]);
      if (k < 9) repeat (p) @(negedge clk);
    end
    chk(req, got, 10'h3FF);
    repeat (p) @(negedge clk);
    chk({req, " R12 released"}, line_oe, 0);
  endtask

  task automatic enter_mode(input logic s, input logic f);
    @(negedge clk);
    strap_hi = s; force_hi = f; mode_enter = 1;
    @(negedge clk);
    mode_enter = 0;
  endtask

  initial begin
    repeat (1000 * 60) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int b0, f0, r0, hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 line_oe", line_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);
    // R1: long period before any mode entry
    host_byte(8'h81, PH, 1);
    enter_mode(1, 0);

    // R2: several byte patterns
    host_byte(8'hA5, PH, 1);
    host_byte(8'h3C, PH, 1);
    host_byte(8'hFF, PH, 1);
    chk("R2 queue drained", exp_q.size(), 0);

    // R4: transmit frames
    tx_expect(8'h96, PH, "R4 tx 96");
    tx_expect(8'h01, PH, "R4 tx 01");

    // R3: stall the consumer, second byte dropped
    rx_ready = 0;
    host_byte(8'h5A, PH, 1);
    host_byte(8'hC3, PH, 0);
    chk("R3 held valid", rx_valid, 1);
    chk("R3 held data", rx_data, 8'h5A);
    rx_ready = 1;
    repeat (4) @(negedge clk);
    chk("R3 drop newer", exp_q.size(), 0);
    chk("R3 no extra valid", rx_valid, 0);

    // R5/R6: break detection and answer
    b0 = brk_cnt; f0 = ferr_cnt; r0 = rx_cnt; hi = 0; lo = 0;
    fork
      host_bits(12'h000, 10, PH);
      begin
        for (int i = 0; i < 40 * PH && !line_oe; i++) @(negedge clk);
        while (line_oe && line_out) begin hi++; @(negedge clk); end
        while (line_oe && !line_out) begin lo++; @(negedge clk); end
      end
    join
    repeat (PH) @(negedge clk);
    chk("R5 brk pulse", brk_cnt - b0, 1);
    chk("R5 no ferr", ferr_cnt - f0, 0);
    chk("R5 no byte", rx_cnt - r0, 0);
    chk("R6 high span", hi, 2 * PH);
    chk("R6 low span", lo, 10 * PH);
    chk("R6 released", line_oe, 0);

    // R7: framing error
    f0 = ferr_cnt; r0 = rx_cnt;
    host_bits({2'b00, 8'h5A, 1'b0}, 10, PH);
    repeat (PH) @(negedge clk);
    chk("R7 ferr pulse", ferr_cnt - f0, 1);
    chk("R7 no byte", rx_cnt - r0, 0);

    // R11: short glitch ignored
    f0 = ferr_cnt; r0 = rx_cnt; b0 = brk_cnt;
    host_drv = 0;
    repeat (PH/4) @(negedge clk);
    host_drv = 1;
    repeat (12 * PH) @(negedge clk);
    chk("R11 no byte", rx_cnt - r0, 0);
    chk("R11 no error", ferr_cnt - f0 + brk_cnt - b0, 0);
    host_byte(8'h77, PH, 1);

    // R10: request held during reception
    fork
      host_byte(8'h42, PH, 1);
      begin
        repeat (3 * PH) @(negedge clk);
        tx_valid = 1; tx_data = 8'hE7;
        @(negedge clk);
        chk("R10 ready low in rx", tx_ready, 0);
        chk("R10 line not driven", line_oe, 0);
        tx_expect(8'hE7, PH, "R10 held tx");
      end
    join
    chk("R10 rx delivered", exp_q.size(), 0);

    // R8: strap low selects the short period; later strap change ignored
    enter_mode(0, 0);
    host_byte(8'h6B, PL, 1);
    tx_expect(8'hD2, PL, "R8 tx short");
    strap_hi = 1;
    host_byte(8'h19, PL, 1);
    tx_expect(8'h2D, PL, "R8 strap ignored");
    chk("R8 queue drained", exp_q.size(), 0);

    // R9: force overrides a low strap
    enter_mode(0, 1);
    host_byte(8'hB4, PH, 1);
    tx_expect(8'h4B, PH, "R9 tx forced");
    chk("R9 queue drained", exp_q.size(), 0);

    finish_run();
  end
endmodule